// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches a set of already-synchronized general-purpose input pins, grouped into banks of 32, and raises a single combined interrupt request. Each pin has its own trigger setting. Two configuration bits pick edge or level sensing and the active sense (rising/high or falling/low). A third bit makes an edge-sensed pin fire on either transition. Detected events are latched into a per-pin status bit, and software clears that bit by writing a 1 to it.

Software gates each pin with a mask bit. The mask cannot be written directly. Writing 1s to an unmask register clears mask bits, writing 1s to a set-mask register sets them, and a read-only register shows the current mask. The combined request is the OR, over all banks, of status bits whose pin is unmasked. Status latches whether the pin is masked or not.

All registers sit on a simple 32-bit register bus. Writes take effect at the clock edge. Read data is a combinational function of the address. Edges are found by comparing each pin with its value one clock earlier.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is held, every bank's mask register reads 0xFFFFFFFF, its status, edge-select, polarity and both-edge registers read 0, and `irq_out` is 0.
- R2: Bank b's window starts at address 0x200 + 0x40·b. The offsets within it are: mask (read-only) +0x0C, unmask (write-only) +0x10, set-mask (write-only) +0x14, status +0x18, edge-select +0x1C, polarity +0x20, both-edge +0x24. Write-only registers read as 0. A write to the mask offset is ignored. `bus_rdata` reflects `bus_addr` in the same cycle.
- R3: With edge-select bit 1 and both-edge bit 0, a pin sets its status bit at the first clock edge where its value differs from the value at the previous edge. Only a 0→1 change counts when polarity is 1, and only a 1→0 change counts when polarity is 0.
- R4: With edge-select 1 and both-edge 1, either transition sets the status bit, whatever the polarity.
- R5: With edge-select 0, the status bit is set at every clock edge where the pin equals its polarity bit (1 = high, 0 = low). The both-edge bit has no effect. A clear while the level persists leaves the bit set.
- R6: Writing the status register clears each bit written as 1. Bits written as 0 keep their value.
- R7: When a new event and a clear of the same status bit occur at the same clock edge, the bit stays set.
- R8: Writing 1s to unmask clears those mask bits, and writing 1s to set-mask sets them. Bits written as 0 leave the mask unchanged.
- R9: A status bit latches an event even while its pin is masked.
- R10: `irq_out` is 1 exactly when some bank has a status bit set whose mask bit is 0. It follows register updates in the same cycle.
- R11: A write to one bank's window changes no register of another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_BANKS*PINS | Synchronized pin values, bank b at bits [32b+31:32b] |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A wrong edge history or trigger decode shows up as a status bit that is missing or set spuriously. That mismatch can be read on the bus at the first clock edge after the pin stimulus. A corrupted mask or status register appears on `irq_out` in the same cycle, since the request is a direct combination of those registers. The race between an event and a clear, and the re-set of a level pin after a clear, are read back the cycle after the write. Both are therefore visible one cycle after the faulty edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Register offsets inside one bank window; software decodes these
    typedef enum logic [5:0] {
        OFF_MASK    = 6'h0C,
        OFF_UNMASK  = 6'h10,
        OFF_SETMASK = 6'h14,
        OFF_STATUS  = 6'h18,
        OFF_EDGESEL = 6'h1C,
        OFF_POL     = 6'h20,
        OFF_BOTH    = 6'h24
    } bank_off_e;

    // First bank window begins at 0x200 -> 64-byte block index 8
    localparam int BANK_BLK0 = 8;
    localparam int OFF_W     = 6;
    localparam int DATA_W    = 32;

    // Per-pin trigger decision from current and previous sample
    function automatic logic pin_trigger(
        input logic now_v,
        input logic prev_v,
        input logic edge_sel,
        input logic pol,
        input logic both
    );
        logic hit;
        if (!edge_sel)
            hit = (now_v == pol);
        else if (both)
            hit = now_v ^ prev_v;
        else if (pol)
            hit = now_v & ~prev_v;
        else
            hit = ~now_v & prev_v;
        return hit;
    endfunction

endpackage

// File: rtl/pin_event_detect.sv
module pin_event_detect
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic [PINS-1:0] pins,
    input  logic [PINS-1:0] edge_sel,
    input  logic [PINS-1:0] pol,
    input  logic [PINS-1:0] both,
    output logic [PINS-1:0] evt
);

    // History of the pins; tracks input also during reset so that no
    // false edge is seen when reset is released
    logic [PINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        prev_q <= pins;
    end

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign evt[p] = pin_trigger(pins[p], prev_q[p], edge_sel[p], pol[p], both[p]);
    end

endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pins,
    input  logic              sel,
    input  logic              wr,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [PINS-1:0]   sts_o,
    output logic [PINS-1:0]   mask_o,
    output logic [PINS-1:0]   evt_o,
    output logic              pend
);

    logic [PINS-1:0] mask_q, sts_q, edge_q, pol_q, both_q;
    logic [PINS-1:0] evt;
    logic [PINS-1:0] wbits;
    logic            wr_en;

    assign wbits = wdata[PINS-1:0];
    assign wr_en = sel & wr;

    pin_event_detect #(.PINS(PINS)) u_det (
        .clk      (clk),
        .pins     (pins),
        .edge_sel (edge_q),
        .pol      (pol_q),
        .both     (both_q),
        .evt      (evt)
    );

    // Configuration and mask registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            edge_q <= '0;
            pol_q  <= '0;
            both_q <= '0;
        end else if (wr_en) begin
            case (off)
                OFF_UNMASK:  mask_q <= mask_q & ~wbits;
                OFF_SETMASK: mask_q <= mask_q | wbits;
                OFF_EDGESEL: edge_q <= wbits;
                OFF_POL:     pol_q  <= wbits;
                OFF_BOTH:    both_q <= wbits;
                default:     ;
            endcase
        end
    end

    // Status: write-1 clear, a same-cycle event wins
    logic [PINS-1:0] clr;
    assign clr = (wr_en && off == OFF_STATUS) ? wbits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sts_q <= '0;
        else
            sts_q <= (sts_q & ~clr) | evt;
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            case (off)
                OFF_MASK:    rdata[PINS-1:0] = mask_q;
                OFF_STATUS:  rdata[PINS-1:0] = sts_q;
                OFF_EDGESEL: rdata[PINS-1:0] = edge_q;
                OFF_POL:     rdata[PINS-1:0] = pol_q;
                OFF_BOTH:    rdata[PINS-1:0] = both_q;
                default:     rdata = '0;
            endcase
        end
    end

    assign pend   = |(sts_q & ~mask_q);
    assign sts_o  = sts_q;
    assign mask_o = mask_q;
    assign evt_o  = evt;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int PINS      = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_BANKS*PINS-1:0] pin_in,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      irq_out
);

    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int TOT   = NUM_BANKS * PINS;

    logic [BLK_W-1:0]  blk;
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] rd_bank [NUM_BANKS];
    logic [NUM_BANKS-1:0] pend;
    logic [TOT-1:0]    sts_vec, mask_vec, evt_vec;

    assign blk = bus_addr[ADDR_W-1:OFF_W];
    assign off = bus_addr[OFF_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (blk == BLK_W'(BANK_BLK0 + b));

        irq_bank #(.PINS(PINS)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .pins   (pin_in[b*PINS +: PINS]),
            .sel    (hit),
            .wr     (bus_wr),
            .off    (off),
            .wdata  (bus_wdata),
            .rdata  (rd_bank[b]),
            .sts_o  (sts_vec[b*PINS +: PINS]),
            .mask_o (mask_vec[b*PINS +: PINS]),
            .evt_o  (evt_vec[b*PINS +: PINS]),
            .pend   (pend[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            bus_rdata = bus_rdata | rd_bank[b];
    end

    assign irq_out = |pend;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
    parameter int TOT = 128
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic           irq_out,
    input logic [TOT-1:0] sts_vec,
    input logic [TOT-1:0] mask_vec,
    input logic [TOT-1:0] evt_vec
);

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec != '0) |=> ((sts_vec & $past(evt_vec)) == $past(evt_vec)));  // R7

    AST_NO_SPONTANEOUS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_vec & ~$past(sts_vec) & ~$past(evt_vec)) == '0));  // R3

    AST_MASK_SET_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_vec & ~$past(mask_vec)) != '0) |-> $past(bus_wr));  // R8

    AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((sts_vec & ~mask_vec) != '0));  // R10

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_vec == '1) |-> !irq_out);  // R10

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.TOT(NUM_BANKS*PINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .irq_out  (irq_out),
    .sts_vec  (sts_vec),
    .mask_vec (mask_vec),
    .evt_vec  (evt_vec)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;

    localparam int NB = 4;
    localparam int NP = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NB*NP-1:0] pin_in = '0;
    logic [11:0]    bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           irq_out;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    gpio_irq_ctrl #(.NUM_BANKS(NB), .PINS(NP), .ADDR_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    // offsets
    localparam logic [11:0] O_MASK = 12'h0C, O_EN = 12'h10, O_DIS = 12'h14,
                            O_STS = 12'h18, O_TYPE = 12'h1C, O_POL = 12'h20,
                            O_ANY = 12'h24;

    function automatic logic [11:0] ra(input int b, input logic [11:0] o);
        return 12'(32'h200 + 32'h40 * b) + o;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic check_reg(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset();
        for (int b = 0; b < NB; b++) begin
            check_reg("R1 mask", ra(b, O_MASK), 32'hFFFF_FFFF);
            check_reg("R1 status", ra(b, O_STS), 32'h0);
            check_reg("R1 type", ra(b, O_TYPE), 32'h0);
            check_reg("R1 pol", ra(b, O_POL), 32'h0);
            check_reg("R1 any", ra(b, O_ANY), 32'h0);
        end
        check("R1 irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_setup();
        for (int b = 0; b < NB; b++) begin
            wr(ra(b, O_TYPE), 32'hFFFF_FFFF);
            wr(ra(b, O_POL), 32'hFFFF_FFFF);
            wr(ra(b, O_ANY), 32'h0);
            wr(ra(b, O_STS), 32'hFFFF_FFFF);
            check_reg("R6 clear all", ra(b, O_STS), 32'h0);
        end
    endtask

    task automatic t_rise();
        pin_in[3] = 1'b1; tick();
        check_reg("R3 rising sets", ra(0, O_STS), 32'h8);
        check("R9 masked no irq", {31'b0, irq_out}, 32'h0);
        wr(ra(0, O_STS), 32'h8);
        check_reg("R6 clear bit", ra(0, O_STS), 32'h0);
        pin_in[3] = 1'b0; tick();
        check_reg("R3 falling ignored", ra(0, O_STS), 32'h0);
    endtask

    task automatic t_fall();
        wr(ra(0, O_POL), 32'hFFFF_FFDF);
        pin_in[5] = 1'b1; tick();
        check_reg("R3 rise ignored pol0", ra(0, O_STS), 32'h0);
        pin_in[5] = 1'b0; tick();
        check_reg("R3 falling sets", ra(0, O_STS), 32'h20);
        wr(ra(0, O_STS), 32'h20);
    endtask

    task automatic t_both();
        wr(ra(1, O_ANY), 32'h1);
        wr(ra(1, O_POL), 32'hFFFF_FFFE);
        pin_in[32] = 1'b1; tick();
        check_reg("R4 rise", ra(1, O_STS), 32'h1);
        wr(ra(1, O_STS), 32'h1);
        pin_in[32] = 1'b0; tick();
        check_reg("R4 fall", ra(1, O_STS), 32'h1);
        wr(ra(1, O_STS), 32'h1);
        check_reg("R11 bank0 any untouched", ra(0, O_ANY), 32'h0);
        check_reg("R11 bank2 pol untouched", ra(2, O_POL), 32'hFFFF_FFFF);
    endtask

    task automatic t_level();
        wr(ra(2, O_TYPE), 32'hFFFF_FFFE);
        tick();
        check_reg("R5 inactive level", ra(2, O_STS), 32'h0);
        pin_in[64] = 1'b1; tick();
        check_reg("R5 high level", ra(2, O_STS), 32'h1);
        wr(ra(2, O_STS), 32'h1);
        check_reg("R5 re-set after clear", ra(2, O_STS), 32'h1);
        pin_in[64] = 1'b0; tick();
        wr(ra(2, O_STS), 32'h1);
        check_reg("R5 clear when inactive", ra(2, O_STS), 32'h0);
        wr(ra(2, O_ANY), 32'h1); tick();
        check_reg("R5 any ignored", ra(2, O_STS), 32'h0);
        wr(ra(2, O_POL), 32'hFFFF_FFFE); tick();
        check_reg("R5 low level", ra(2, O_STS), 32'h1);
        wr(ra(2, O_POL), 32'hFFFF_FFFF);
        wr(ra(2, O_STS), 32'h1);
        check_reg("R5 restored", ra(2, O_STS), 32'h0);
    endtask

    task automatic t_mask();
        pin_in[103] = 1'b1; tick();
        check_reg("R9 status while masked", ra(3, O_STS), 32'h80);
        check("R10 masked", {31'b0, irq_out}, 32'h0);
        wr(ra(3, O_EN), 32'h80);
        check_reg("R8 unmask", ra(3, O_MASK), 32'hFFFF_FF7F);
        check("R10 unmasked irq", {31'b0, irq_out}, 32'h1);
        wr(ra(3, O_EN), 32'h0);
        check_reg("R8 zero no effect", ra(3, O_MASK), 32'hFFFF_FF7F);
        wr(ra(3, O_MASK), 32'h0);
        check_reg("R2 mask read-only", ra(3, O_MASK), 32'hFFFF_FF7F);
        check_reg("R2 enable reads 0", ra(3, O_EN), 32'h0);
        wr(ra(3, O_DIS), 32'h80);
        check_reg("R8 set-mask", ra(3, O_MASK), 32'hFFFF_FFFF);
        check("R10 remasked", {31'b0, irq_out}, 32'h0);
        wr(ra(3, O_EN), 32'h80);
        check("R10 irq again", {31'b0, irq_out}, 32'h1);
        wr(ra(3, O_STS), 32'h0);
        check_reg("R6 write 0 keeps", ra(3, O_STS), 32'h80);
    endtask

    task automatic t_race();
        pin_in[103] = 1'b0; tick();
        wr(ra(3, O_STS), 32'h80);
        check("R10 cleared irq", {31'b0, irq_out}, 32'h0);
        pin_in[103] = 1'b1;
        wr(ra(3, O_STS), 32'h80);
        check_reg("R7 event beats clear", ra(3, O_STS), 32'h80);
        check("R7 irq", {31'b0, irq_out}, 32'h1);
        wr(ra(3, O_STS), 32'h80);
        check_reg("R6 final clear", ra(3, O_STS), 32'h0);
        check("R10 idle", {31'b0, irq_out}, 32'h0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_setup();
        t_rise();
        t_fall();
        t_both();
        t_level();
        t_mask();
        t_race();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule